// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block is a bus master for an external memory or peripheral bus. The low sixteen address bits and the data share one bidirectional port, and an outside latch captures the address. An internal requester presents one access on a valid/ready request channel. The access carries a full address, write data, a read/write flag and a word/byte flag. A separate control pin selects whether the external data path is 8 or 16 bits wide. The block then runs one external cycle in three timed phases. In the first phase, address latch enable is high and the address is on the shared port. In the second phase, latch enable is low and the address stays on the port so the latch can hold it. In the third phase, the address is gone and the active-low command strobe is asserted.

The bits of the address above bit 15 go out on their own port and need no latch. Read data is sampled at the last clock edge of the command phase. It is returned with a one-cycle completion pulse. The request channel applies back-pressure: `req_ready` is high only while the block is idle, and a request transfers on a clock edge where `req_valid` and `req_ready` are both high. The response is a bare pulse and cannot be stalled. Three configuration inputs set the length, in clocks, of each phase.

Top module: `mux_bus_ctrl`

## Requirements
- R1: During and right after reset, all four strobes (`rd_n`, `wr_n`, `wrl_n`, `wrh_n`) are high, `ale` is low, `ad_oe` is 2'b00 (both lanes tri-stated), `rsp_valid` is low and `req_ready` is high.
- R2: `req_ready` is high exactly when no external cycle is in progress. A request taken on a clock edge makes `ale` high in the very next cycle, and `req_ready` stays low until the completion cycle.
- R3: The latch-enable, address-hold and command phases last `cfg_ale_len`, `cfg_hold_len` and `cfg_cmd_len` clocks respectively. A count of 0 acts as 1. Each count is read when its phase begins.
- R4: Through the latch-enable and address-hold phases, `ad_oe` is 2'b11 and `ad_out` carries address bits 15..0, with bit 0 forced to 0 for a word access on the 16-bit bus. No strobe is low in these phases, and `ale` is low during the hold phase.
- R5: The strobe is low only during the command phase. A read uses `rd_n`. A write on the 8-bit bus (`bus_wide`=0) uses `wr_n` and ignores `req_word`. On the 16-bit bus, a word write (`req_word`=1) uses both `wrl_n` and `wrh_n`. A 16-bit byte write uses only `wrl_n` when address bit 0 is 0 and only `wrh_n` when it is 1.
- R6: During a read's command phase on the 8-bit bus, `ad_oe`=2'b10 and `ad_out[15:8]` still holds address bits 15..8. On the 16-bit bus, `ad_oe`=2'b00.
- R7: In a write's command phase, `ad_oe`=2'b11 and `ad_out` carries one of three patterns. On the 8-bit bus it is {address[15:8], wdata[7:0]}. For a 16-bit word write it is wdata. For a 16-bit byte write it is wdata[7:0] on both lanes. This drive continues unchanged after completion until the next cycle's latch-enable phase.
- R8: After a read completes, `ad_oe` is 2'b00 until the next cycle starts.
- R9: `up_addr` carries address bits above 15 from the first latch-enable cycle on. It stays unchanged for the whole cycle and until the next request is taken.
- R10: `rsp_valid` is high for exactly one cycle, the cycle right after the last command-phase clock. For a read, `rsp_rdata` holds the sampled `ad_in`, selected and zero-extended as follows. On the 8-bit bus it is {8'h00, ad_in[7:0]}. For a 16-bit word read it is the full ad_in. For a 16-bit byte read it is the low lane when address bit 0 is 0 and the high lane when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wide | input | 1 | External data width: 1 = 16-bit, 0 = 8-bit; taken with the request |
| cfg_ale_len | input | CNT_W | Latch-enable phase length in clocks (0 acts as 1) |
| cfg_hold_len | input | CNT_W | Address-hold phase length in clocks (0 acts as 1) |
| cfg_cmd_len | input | CNT_W | Command phase length in clocks (0 acts as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | ADDR_W | Full access address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access (16-bit bus only) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid on reads |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe for the 8-bit bus, active low |
| wrl_n | output | 1 | Low-lane write strobe, active low |
| wrh_n | output | 1 | High-lane write strobe, active low |
| ad_out | output | 16 | Shared address/data port, outgoing value |
| ad_oe | output | 2 | Per-lane output enable, bit 1 = high lane |
| ad_in | input | 16 | Shared address/data port, incoming value |
| up_addr | output | ADDR_W-16 | Upper address bits, unlatched |

## Verification
The bench sets zero phase counts to check that each acts as one clock. A design that used zero literally would collapse a phase or wrap its counter into a very long phase. Sixteen-bit byte writes at even and odd addresses, and word writes at odd addresses, check lane strobe selection and the forced-zero bit 0. A mistake there would pulse the wrong lane strobe or latch an odd word address. The idle cycles after each access are also checked. A design that dropped write data early, or kept driving after a read, would show the wrong `ad_oe` there. On 8-bit reads, the bench checks that the high lane keeps its address, and it checks high-lane read extraction. A design that released the whole port or took the wrong lane would return bad data.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ALE  = 2'd1,
    PH_HOLD = 2'd2,
    PH_CMD  = 2'd3
  } phase_t;

  typedef struct packed {
    logic        write;
    logic        word;
    logic        wide;
    logic [15:0] addr;
    logic [15:0] wdata;
  } acc_t;
endpackage

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len_ale,
  input  logic [CNT_W-1:0] len_hold,
  input  logic [CNT_W-1:0] len_cmd,
  output phase_t           phase,
  output logic             finish
);
  logic [CNT_W-1:0] remain;

  function automatic logic [CNT_W-1:0] first_val(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      remain <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_ALE;
          remain <= first_val(len_ale);
        end
        PH_ALE: if (remain == '0) begin
          phase  <= PH_HOLD;
          remain <= first_val(len_hold);
        end else begin
          remain <= remain - 1'b1;
        end
        PH_HOLD: if (remain == '0) begin
          phase  <= PH_CMD;
          remain <= first_val(len_cmd);
        end else begin
          remain <= remain - 1'b1;
        end
        PH_CMD: if (remain == '0) begin
          phase <= PH_IDLE;
        end else begin
          remain <= remain - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign finish = (phase == PH_CMD) && (remain == '0);
endmodule

// File: rtl/mux_bus_strobe.sv
module mux_bus_strobe
  import mux_bus_pkg::*;
(
  input  phase_t phase,
  input  acc_t   acc,
  output logic   rd_n,
  output logic   wr_n,
  output logic   wrl_n,
  output logic   wrh_n
);
  logic cmd_on;
  assign cmd_on = (phase == PH_CMD);

  always_comb begin
    rd_n  = 1'b1;
    wr_n  = 1'b1;
    wrl_n = 1'b1;
    wrh_n = 1'b1;
    if (cmd_on) begin
      if (!acc.write) begin
        rd_n = 1'b0;
      end else if (!acc.wide) begin
        wr_n = 1'b0;
      end else if (acc.word) begin
        wrl_n = 1'b0;
        wrh_n = 1'b0;
      end else if (acc.addr[0]) begin
        wrh_n = 1'b0;
      end else begin
        wrl_n = 1'b0;
      end
    end
  end
endmodule

// File: rtl/mux_bus_lanes.sv
module mux_bus_lanes
  import mux_bus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  phase_t      phase,
  input  logic        start,
  input  logic        finish,
  input  acc_t        acc,
  input  logic [15:0] ad_in,
  output logic [15:0] ad_out,
  output logic [1:0]  ad_oe,
  output logic [15:0] rdata
);
  logic        park_wr;
  logic [15:0] addr_pat;
  logic [15:0] wr_pat;
  logic [15:0] rd_pick;

  assign addr_pat = (acc.wide && acc.word) ? {acc.addr[15:1], 1'b0} : acc.addr;

  always_comb begin
    if (!acc.wide)     wr_pat = {acc.addr[15:8], acc.wdata[7:0]};
    else if (acc.word) wr_pat = acc.wdata;
    else               wr_pat = {acc.wdata[7:0], acc.wdata[7:0]};
  end

  always_comb begin
    if (!acc.wide)         rd_pick = {8'h00, ad_in[7:0]};
    else if (acc.word)     rd_pick = ad_in;
    else if (acc.addr[0])  rd_pick = {8'h00, ad_in[15:8]};
    else                   rd_pick = {8'h00, ad_in[7:0]};
  end

  always_comb begin
    ad_out = 16'h0000;
    ad_oe  = 2'b00;
    unique case (phase)
      PH_ALE, PH_HOLD: begin
        ad_out = addr_pat;
        ad_oe  = 2'b11;
      end
      PH_CMD: begin
        if (acc.write) begin
          ad_out = wr_pat;
          ad_oe  = 2'b11;
        end else if (!acc.wide) begin
          ad_out = {acc.addr[15:8], 8'h00};
          ad_oe  = 2'b10;
        end
      end
      default: begin
        if (park_wr) begin
          ad_out = wr_pat;
          ad_oe  = 2'b11;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      park_wr <= 1'b0;
      rdata   <= 16'h0000;
    end else begin
      if (start)
        park_wr <= 1'b0;
      else if (finish)
        park_wr <= acc.write;
      if (finish && !acc.write)
        rdata <= rd_pick;
    end
  end
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wide,
  input  logic [CNT_W-1:0]  cfg_ale_len,
  input  logic [CNT_W-1:0]  cfg_hold_len,
  input  logic [CNT_W-1:0]  cfg_cmd_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic              req_write,
  input  logic              req_word,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              wrl_n,
  output logic              wrh_n,
  output logic [15:0]       ad_out,
  output logic [1:0]        ad_oe,
  input  logic [15:0]       ad_in,
  output logic [ADDR_W-17:0] up_addr
);
  localparam int UP_W = ADDR_W - 16;

  phase_t phase;
  logic   start;
  logic   finish;
  acc_t   acc;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign ale       = (phase == PH_ALE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      up_addr   <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= finish;
      if (start) begin
        acc.write <= req_write;
        acc.word  <= req_word;
        acc.wide  <= bus_wide;
        acc.addr  <= req_addr[15:0];
        acc.wdata <= req_wdata;
        up_addr   <= req_addr[ADDR_W-1 -: UP_W];
      end
    end
  end

  mux_bus_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .len_ale  (cfg_ale_len),
    .len_hold (cfg_hold_len),
    .len_cmd  (cfg_cmd_len),
    .phase    (phase),
    .finish   (finish)
  );

  mux_bus_strobe u_strobe (
    .phase (phase),
    .acc   (acc),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .wrl_n (wrl_n),
    .wrh_n (wrh_n)
  );

  mux_bus_lanes u_lanes (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .start  (start),
    .finish (finish),
    .acc    (acc),
    .ad_in  (ad_in),
    .ad_out (ad_out),
    .ad_oe  (ad_oe),
    .rdata  (rsp_rdata)
  );
endmodule

// File: rtl/mux_bus_ctrl_chk.sv
module mux_bus_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n,
  input logic              wrl_n,
  input logic              wrh_n,
  input logic [1:0]        ad_oe,
  input logic [ADDR_W-17:0] up_addr
);
  logic cmd_on;
  logic wr_any;
  assign wr_any = !wr_n || !wrl_n || !wrh_n;
  assign cmd_on = !rd_n || wr_any;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> (rd_n && wr_n && wrl_n && wrh_n && !ale && ad_oe == 2'b00)); // R1
  AST_ACCEPT_ALE: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> (ale && !req_ready)); // R2
  AST_ALE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n) ale |-> (!cmd_on && ad_oe == 2'b11)); // R4
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && wr_any)); // R5
  AST_RD_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe[0]); // R6
  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) wr_any |-> (ad_oe == 2'b11)); // R7
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cmd_on && !req_ready) |=> $stable(up_addr)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (req_ready && !cmd_on)); // R10
endmodule

bind mux_bus_ctrl mux_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .wrl_n     (wrl_n),
  .wrh_n     (wrh_n),
  .ad_oe     (ad_oe),
  .up_addr   (up_addr)
);

// File: tb/mux_bus_ctrl_test.sv
module mux_bus_ctrl_test;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 4;
  localparam int UP_W   = ADDR_W - 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wide = 1'b0;
  logic [CNT_W-1:0] cfg_ale_len = '0, cfg_hold_len = '0, cfg_cmd_len = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_write = 1'b0, req_word = 1'b0;
  logic rsp_valid;
  logic [15:0] rsp_rdata;
  logic ale, rd_n, wr_n, wrl_n, wrh_n;
  logic [15:0] ad_out;
  logic [1:0] ad_oe;
  logic [15:0] ad_in = '0;
  logic [UP_W-1:0] up_addr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mux_bus_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide),
    .cfg_ale_len(cfg_ale_len), .cfg_hold_len(cfg_hold_len), .cfg_cmd_len(cfg_cmd_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_word(req_word),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .wrl_n(wrl_n), .wrh_n(wrh_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .up_addr(up_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] strobes_now();
    return {~rd_n, ~wr_n, ~wrl_n, ~wrh_n};
  endfunction

  function automatic logic [3:0] exp_strobe(input bit wr, input bit wide, input bit word, input bit a0);
    if (!wr) return 4'b1000;
    if (!wide) return 4'b0100;
    if (word) return 4'b0011;
    return a0 ? 4'b0001 : 4'b0010;
  endfunction

  function automatic logic [15:0] exp_wpat(input bit wide, input bit word, input logic [15:0] a, input logic [15:0] d);
    if (!wide) return {a[15:8], d[7:0]};
    if (word) return d;
    return {d[7:0], d[7:0]};
  endfunction

  function automatic logic [15:0] exp_rd(input bit wide, input bit word, input bit a0, input logic [15:0] v);
    if (!wide) return {8'h00, v[7:0]};
    if (word) return v;
    return a0 ? {8'h00, v[15:8]} : {8'h00, v[7:0]};
  endfunction

  function automatic int eff(input logic [CNT_W-1:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  task automatic run(input bit wr, input bit wide, input bit word, input logic [ADDR_W-1:0] addr,
                     input logic [15:0] wd, input logic [CNT_W-1:0] na, input logic [CNT_W-1:0] nh,
                     input logic [CNT_W-1:0] nc, input logic [15:0] rv);
    logic [15:0] a16, aexp, wpat;
    int ea, eh, ec;
    a16  = addr[15:0];
    aexp = (wide && word) ? {a16[15:1], 1'b0} : a16;
    wpat = exp_wpat(wide, word, a16, wd);
    ea = eff(na); eh = eff(nh); ec = eff(nc);
    @(negedge clk);
    chk("R2 ready before request", {31'b0, req_ready}, 1);
    bus_wide = wide; req_write = wr; req_word = word; req_addr = addr; req_wdata = wd;
    cfg_ale_len = na; cfg_hold_len = nh; cfg_cmd_len = nc; ad_in = rv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~addr;
    for (int j = 1; j <= ea + eh + ec; j++) begin
      chk("R2 ready low while busy", {31'b0, req_ready}, 0);
      chk("R9 upper address", {24'b0, up_addr}, {24'b0, addr[ADDR_W-1:16]});
      chk("R10 no early done", {31'b0, rsp_valid}, 0);
      if (j <= ea) begin
        chk("R3 R4 ale phase", {31'b0, ale}, 1);
        chk("R4 address drive", {14'b0, ad_oe, ad_out}, {14'b0, 2'b11, aexp});
        chk("R4 no strobe in ale", {28'b0, strobes_now()}, 0);
      end else if (j <= ea + eh) begin
        chk("R3 R4 hold phase ale low", {31'b0, ale}, 0);
        chk("R4 address held", {14'b0, ad_oe, ad_out}, {14'b0, 2'b11, aexp});
        chk("R3 R5 no strobe in hold", {28'b0, strobes_now()}, 0);
      end else begin
        chk("R3 R5 command strobe", {28'b0, strobes_now()}, {28'b0, exp_strobe(wr, wide, word, a16[0])});
        chk("R3 ale low in command", {31'b0, ale}, 0);
        if (wr)
          chk("R7 write data drive", {14'b0, ad_oe, ad_out}, {14'b0, 2'b11, wpat});
        else if (!wide)
          chk("R6 8-bit read lanes", {22'b0, ad_oe, ad_out[15:8]}, {22'b0, 2'b10, a16[15:8]});
        else
          chk("R6 16-bit read release", {30'b0, ad_oe}, 0);
      end
      @(negedge clk);
    end
    chk("R10 done pulse", {31'b0, rsp_valid}, 1);
    chk("R3 R5 strobes released", {28'b0, strobes_now()}, 0);
    chk("R2 ready at done", {31'b0, req_ready}, 1);
    if (!wr) chk("R10 read data", {16'b0, rsp_rdata}, {16'b0, exp_rd(wide, word, a16[0], rv)});
    ad_in = ~rv;
    for (int k = 0; k < 2; k++) begin
      if (wr) chk("R7 write data persists", {14'b0, ad_oe, ad_out}, {14'b0, 2'b11, wpat});
      else    chk("R8 port released after read", {30'b0, ad_oe}, 0);
      chk("R9 upper address kept", {24'b0, up_addr}, {24'b0, addr[ADDR_W-1:16]});
      @(negedge clk);
      chk("R10 single pulse", {31'b0, rsp_valid}, 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    #1;
    chk("R1 reset strobes", {28'b0, strobes_now()}, 0);
    chk("R1 reset ale oe", {29'b0, ale, ad_oe}, 0);
    chk("R1 reset handshake", {30'b0, rsp_valid, req_ready}, {30'b0, 2'b01});
    #9 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {27'b0, rsp_valid, ale, rd_n, ad_oe}, {27'b0, 5'b00100});

    // directed corner cases
    run(1, 0, 0, 24'h12A5C3, 16'hBEEF, 0, 0, 0, 16'h0);      // zero counts act as one
    run(0, 0, 0, 24'h34F00D, 16'h0, 15, 15, 15, 16'hA55A);   // longest phases, 8-bit read
    run(1, 1, 0, 24'h560010, 16'h00C7, 1, 2, 3, 16'h0);      // byte write even
    run(1, 1, 0, 24'h560011, 16'h0093, 2, 1, 1, 16'h0);      // byte write odd
    run(1, 1, 1, 24'h7A1235, 16'hCAFE, 1, 1, 2, 16'h0);      // word write odd address
    run(0, 1, 0, 24'h7A1237, 16'h0, 1, 1, 1, 16'h9E42);      // high lane byte read
    run(0, 1, 0, 24'h7A1236, 16'h0, 1, 1, 1, 16'h9E42);      // low lane byte read
    run(0, 1, 1, 24'h7A1237, 16'h0, 3, 1, 2, 16'h1357);      // word read
    run(1, 0, 1, 24'h010203, 16'h4455, 1, 1, 1, 16'h0);      // 8-bit ignores word flag
    run(0, 0, 0, 24'h010203, 16'h0, 1, 1, 1, 16'h6677);      // read after write

    for (int t = 0; t < 150; t++) begin
      run(1'($urandom), 1'($urandom), 1'($urandom), 24'($urandom), 16'($urandom),
          4'($urandom % 5), 4'($urandom % 5), 4'($urandom % 5), 16'($urandom));
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule